// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This engine places incoming frames into memory. Software keeps a ring of receive descriptors and marks each one empty. A frame arrives as a header beat that carries the payload length and a 32-bit frame check value, followed by the payload bytes. The engine walks the ring and scatters the stored stream into the buffers that the descriptors point to. The stored stream is an optional two-byte zero pad, then the payload, then the four check bytes. The engine writes each descriptor back with its fill count and its status flags, and it pulses an event for every buffer it completes.

Two checks apply to the stored stream. A fixed ceiling (parameter `FRAME_CEIL`) truncates it. A programmable limit flags it as too long. The engine keeps a single receive-active bit. A frame that arrives while this bit is clear is consumed and discarded. At the end of every frame the engine refreshes the bit from the descriptor that is next in line. Software can also ask for that refresh through `arm_req`.

Both stream inputs use valid/ready. The source must hold `hdr_len`, `hdr_crc` and `in_data` stable while their valid is high and ready is low. A transfer happens on any clock edge where valid and ready are both high. `hdr_ready` is high only while the engine is idle. Back-pressure on `in_ready` comes from the memory port: a payload byte is taken only in a cycle in which its write is granted. The memory port is a single-beat master. A request completes in the cycle in which `mem_gnt` is high, and read data must be valid in that same cycle.

Top module: `rx_desc_ring`

## Requirements
- R1: While `rx_active` is 0, an accepted header and all of its payload bytes are consumed. The engine makes no memory write and raises no event.
- R2: The stored length is the payload length plus 4, plus 2 more when `shift_en` is 1. The stored bytes are laid out in this order: the pad, the payload in arrival order, then `hdr_crc` with bits 31:24 first.
- R3: If the stored length exceeds `FRAME_CEIL`, it is cut to `FRAME_CEIL`, the last 4 stored bytes are still the check bytes, and the final descriptor gets the truncated flag (bit 0) and the length-error flag (bit 5). The engine still consumes the payload bytes that were not stored.
- R4: A stored length greater than `len_limit` sets the length-error flag without the truncated flag.
- R5: The descriptor is two words. Word 0 holds the flags in bits 31:16 and the length in bits 15:0. Word 1 holds the buffer address. Each buffer gets at most `max_buf & 0x3FF0` bytes. The length field receives the byte count, the empty flag (bit 15) is cleared, and the wrap flag (bit 13) is kept.
- R6: The check bytes may be split across two buffers. The leading bytes close one buffer and the rest open the next one.
- R7: The final descriptor gets the last flag (bit 11) and pulses `frame_evt`. Each earlier descriptor of the frame pulses `buf_evt` and gets no last flag.
- R8: A descriptor without the empty flag that is met before the frame is complete ends the frame. That descriptor is left unwritten, the rest of the payload is consumed, `rx_active` drops to 0, and no `frame_evt` is raised.
- R9: After each written descriptor the pointer moves to `ring_base` if the wrap flag is set, and otherwise moves forward by 8 bytes.
- R10: With `shift_en`, the two zero bytes go only at the start of the first buffer, and they count in that buffer's length.
- R11: After a completed frame, `rx_active` equals the empty flag of the descriptor at the pointer.
- R12: An `arm_req` pulse while `enable` is 1 and `rx_active` is 0 performs the same refresh. While `enable` is 0, `arm_req` is ignored, `rx_active` is held at 0 and the pointer is reloaded from `ring_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable |
| arm_req | input | 1 | Request to refresh the receive-active bit |
| shift_en | input | 1 | Insert a two-byte zero pad before the payload |
| ring_base | input | AW | Byte address of the first descriptor |
| max_buf | input | 16 | Buffer size; only bits 13:4 are used |
| len_limit | input | 16 | Length-error limit |
| hdr_valid | input | 1 | Frame header valid |
| hdr_ready | output | 1 | Frame header ready |
| hdr_len | input | 16 | Payload length in bytes |
| hdr_crc | input | 32 | Check value stored after the payload |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte ready |
| in_data | input | 8 | Payload byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables; lane n is bits 8n+7:8n |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request completes in this cycle |
| mem_rdata | input | 32 | Read data, valid while granted |
| rx_active | output | 1 | Receive-active bit |
| frame_evt | output | 1 | One-cycle pulse: final buffer of a frame written |
| buf_evt | output | 1 | One-cycle pulse: intermediate buffer written |

## Verification
The bench targets the places where byte accounting can go wrong.

- **Check bytes straddling a buffer edge.** A design that put the check bytes only in the final buffer would leave the first buffer short and the final buffer too long.
- **A frame that exactly fills one buffer.** A design with an off-by-one here would write an extra empty descriptor.
- **The pad.** A design that added the pad to every buffer would shift all later buffers by two bytes.
- **Truncation.** A design that truncated without consuming the excess payload would hang the source or corrupt the next frame. The two error flags are checked separately, so a design that confused the ceiling with the limit fails.
- **Abandoning a frame.** A design that walked past a full descriptor would overwrite software's buffer, and a design that kept `rx_active` high would accept the next frame into it.
- **Ring wrap.** The wrap is checked together with memory stalls.

// File: rtl/rxdr_pkg.sv
package rxdr_pkg;
  localparam int LEN_W = 16;
  localparam int FLG_W = 16;
  localparam int F_EMPTY  = 15;
  localparam int F_WRAP   = 13;
  localparam int F_LAST   = 11;
  localparam int F_LENERR = 5;
  localparam int F_TRUNC  = 0;
  localparam int DESC_BYTES = 8;
  localparam logic [LEN_W-1:0] BUF_SIZE_MASK = 16'h3FF0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DROP, ST_FETCH0, ST_FETCH1,
    ST_DATA, ST_WBACK, ST_DRAIN, ST_CHECK
  } rxdr_state_e;

  typedef enum logic [1:0] {SRC_PAD, SRC_PAY, SRC_CRC} rxdr_src_e;
endpackage

// File: rtl/rxdr_len_calc.sv
module rxdr_len_calc
  import rxdr_pkg::*;
#(
  parameter int FRAME_CEIL = 2048
) (
  input  logic [LEN_W-1:0] pay_len,
  input  logic             pad_en,
  input  logic [LEN_W-1:0] limit,
  output logic [LEN_W-1:0] total,
  output logic             trunc,
  output logic             lenerr
);
  localparam int XW = LEN_W + 2;
  localparam logic [XW-1:0] CEIL_X = XW'(FRAME_CEIL);
  localparam logic [LEN_W-1:0] CEIL_L = LEN_W'(FRAME_CEIL);

  logic [XW-1:0] raw;

  always_comb begin
    raw    = {2'b00, pay_len} + XW'(4) + (pad_en ? XW'(2) : XW'(0));
    trunc  = raw > CEIL_X;
    total  = trunc ? CEIL_L : raw[LEN_W-1:0];
    lenerr = trunc || (total > limit);
  end
endmodule

// File: rtl/rxdr_byte_src.sv
module rxdr_byte_src
  import rxdr_pkg::*;
(
  input  logic [LEN_W-1:0] idx,
  input  logic [LEN_W-1:0] total,
  input  logic             pad_en,
  input  logic [31:0]      crc,
  input  logic [7:0]       pay_byte,
  output rxdr_src_e        src,
  output logic [7:0]       byte_out
);
  logic [LEN_W-1:0] tail_start;
  logic [1:0]       crc_sel;

  always_comb begin
    tail_start = total - LEN_W'(4);
    crc_sel    = idx[1:0] - tail_start[1:0];
    if (pad_en && (idx < LEN_W'(2))) begin
      src      = SRC_PAD;
      byte_out = 8'h00;
    end else if (idx >= tail_start) begin
      src = SRC_CRC;
      case (crc_sel)
        2'd0:    byte_out = crc[31:24];
        2'd1:    byte_out = crc[23:16];
        2'd2:    byte_out = crc[15:8];
        default: byte_out = crc[7:0];
      endcase
    end else begin
      src      = SRC_PAY;
      byte_out = pay_byte;
    end
  end
endmodule

// File: rtl/rxdr_ring_ptr.sv
module rxdr_ring_ptr
  import rxdr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic          wrap,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (load)    ptr <= base;
    else if (advance) ptr <= wrap ? base : ptr + AW'(DESC_BYTES);
  end

  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (ptr == $past(base) || ptr == $past(ptr) + AW'(DESC_BYTES)));
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rxdr_pkg::*;
#(
  parameter int AW         = 32,
  parameter int FRAME_CEIL = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             arm_req,
  input  logic             shift_en,
  input  logic [AW-1:0]    ring_base,
  input  logic [LEN_W-1:0] max_buf,
  input  logic [LEN_W-1:0] len_limit,
  input  logic             hdr_valid,
  output logic             hdr_ready,
  input  logic [LEN_W-1:0] hdr_len,
  input  logic [31:0]      hdr_crc,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic             mem_gnt,
  input  logic [31:0]      mem_rdata,
  output logic             rx_active,
  output logic             frame_evt,
  output logic             buf_evt
);
  localparam logic [FLG_W-1:0] EMPTY_M = FLG_W'(1) << F_EMPTY;
  localparam logic [FLG_W-1:0] LAST_M  = FLG_W'(1) << F_LAST;
  localparam logic [FLG_W-1:0] LERR_M  = FLG_W'(1) << F_LENERR;
  localparam logic [FLG_W-1:0] TRUNC_M = FLG_W'(1) << F_TRUNC;

  rxdr_state_e      state_q;
  logic [LEN_W-1:0] total_q, idx_q, bcnt_q, mbs_q, pay_left_q;
  logic             trunc_q, lenerr_q, pad_q, need_check_q, kick_q;
  logic [31:0]      crc_q;
  logic [FLG_W-1:0] dflags_q;
  logic [AW-1:0]    baddr_q;

  logic [LEN_W-1:0] calc_total;
  logic             calc_trunc, calc_lenerr;
  rxdr_src_e        src;
  logic [7:0]       src_byte;
  logic [AW-1:0]    ptr, byte_addr, acc_addr;
  logic             ptr_load, ptr_adv, hdr_fire, take, final_buf;
  logic [FLG_W-1:0] new_flags;

  rxdr_len_calc #(.FRAME_CEIL(FRAME_CEIL)) u_len (
    .pay_len(hdr_len), .pad_en(shift_en), .limit(len_limit),
    .total(calc_total), .trunc(calc_trunc), .lenerr(calc_lenerr)
  );

  rxdr_byte_src u_src (
    .idx(idx_q), .total(total_q), .pad_en(pad_q), .crc(crc_q),
    .pay_byte(in_data), .src(src), .byte_out(src_byte)
  );

  rxdr_ring_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .advance(ptr_adv),
    .wrap(dflags_q[F_WRAP]), .base(ring_base), .ptr(ptr)
  );

  assign hdr_ready = (state_q == ST_IDLE) && !kick_q;
  assign hdr_fire  = hdr_valid && hdr_ready;
  assign ptr_load  = (state_q == ST_IDLE) && !enable;
  assign ptr_adv   = (state_q == ST_WBACK) && mem_gnt;
  assign byte_addr = baddr_q + AW'(bcnt_q);
  assign final_buf = (idx_q == total_q);
  assign take      = mem_req && mem_gnt;
  assign mem_addr  = acc_addr & ~AW'(3);

  always_comb begin
    new_flags = dflags_q & ~EMPTY_M;
    if (final_buf)
      new_flags = new_flags | LAST_M | (lenerr_q ? LERR_M : '0) | (trunc_q ? TRUNC_M : '0);
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    acc_addr  = ptr;
    mem_be    = 4'hF;
    mem_wdata = '0;
    in_ready  = 1'b0;
    case (state_q)
      ST_DROP, ST_DRAIN: in_ready = 1'b1;
      ST_FETCH0, ST_CHECK: mem_req = 1'b1;
      ST_FETCH1: begin
        mem_req  = 1'b1;
        acc_addr = ptr + AW'(4);
      end
      ST_DATA: begin
        mem_req   = (src != SRC_PAY) || in_valid;
        mem_we    = 1'b1;
        acc_addr  = byte_addr;
        mem_be    = 4'b0001 << byte_addr[1:0];
        mem_wdata = {4{src_byte}};
        in_ready  = (src == SRC_PAY) && mem_gnt;
      end
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {new_flags, bcnt_q};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      total_q      <= '0;
      idx_q        <= '0;
      bcnt_q       <= '0;
      mbs_q        <= '0;
      pay_left_q   <= '0;
      trunc_q      <= 1'b0;
      lenerr_q     <= 1'b0;
      pad_q        <= 1'b0;
      need_check_q <= 1'b0;
      kick_q       <= 1'b0;
      crc_q        <= '0;
      dflags_q     <= '0;
      baddr_q      <= '0;
      rx_active    <= 1'b0;
      frame_evt    <= 1'b0;
      buf_evt      <= 1'b0;
    end else begin
      frame_evt <= 1'b0;
      buf_evt   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (!enable) begin
            rx_active <= 1'b0;
            kick_q    <= 1'b0;
          end else if (kick_q) begin
            kick_q       <= 1'b0;
            need_check_q <= 1'b0;
            if (!rx_active) state_q <= ST_CHECK;
          end
          if (hdr_fire) begin
            total_q      <= calc_total;
            trunc_q      <= calc_trunc;
            lenerr_q     <= calc_lenerr;
            pad_q        <= shift_en;
            crc_q        <= hdr_crc;
            pay_left_q   <= hdr_len;
            idx_q        <= '0;
            mbs_q        <= max_buf & BUF_SIZE_MASK;
            need_check_q <= 1'b0;
            if (rx_active)                 state_q <= ST_FETCH0;
            else if (hdr_len != '0)        state_q <= ST_DROP;
          end
        end
        ST_DROP, ST_DRAIN: begin
          if (in_valid) begin
            pay_left_q <= pay_left_q - LEN_W'(1);
            if (pay_left_q == LEN_W'(1))
              state_q <= (state_q == ST_DRAIN && need_check_q) ? ST_CHECK : ST_IDLE;
          end
        end
        ST_FETCH0: begin
          if (mem_gnt) begin
            dflags_q <= mem_rdata[31:16];
            if (!mem_rdata[16+F_EMPTY]) begin
              rx_active    <= 1'b0;
              need_check_q <= 1'b0;
              state_q      <= (pay_left_q != '0) ? ST_DRAIN : ST_IDLE;
            end else begin
              state_q <= ST_FETCH1;
            end
          end
        end
        ST_FETCH1: begin
          if (mem_gnt) begin
            baddr_q <= mem_rdata[AW-1:0];
            bcnt_q  <= '0;
            state_q <= (mbs_q == '0) ? ST_WBACK : ST_DATA;
          end
        end
        ST_DATA: begin
          if (take) begin
            idx_q  <= idx_q + LEN_W'(1);
            bcnt_q <= bcnt_q + LEN_W'(1);
            if (src == SRC_PAY) pay_left_q <= pay_left_q - LEN_W'(1);
            if ((idx_q + LEN_W'(1) == total_q) || (bcnt_q + LEN_W'(1) == mbs_q))
              state_q <= ST_WBACK;
          end
        end
        ST_WBACK: begin
          if (mem_gnt) begin
            frame_evt <= final_buf;
            buf_evt   <= !final_buf;
            if (final_buf) begin
              need_check_q <= 1'b1;
              state_q      <= (pay_left_q != '0) ? ST_DRAIN : ST_CHECK;
            end else begin
              state_q <= ST_FETCH0;
            end
          end
        end
        ST_CHECK: begin
          if (mem_gnt) begin
            rx_active <= mem_rdata[16+F_EMPTY];
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (arm_req && enable && !rx_active) kick_q <= 1'b1;
    end
  end

  // R7
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_evt && buf_evt));

  // R1
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP) |-> !mem_req);

  // R5
  buf_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (bcnt_q < mbs_q));

  // R3
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (idx_q < total_q));

  // R11
  active_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> $past(state_q == ST_CHECK));
endmodule

// File: tb/rx_desc_ring_bench.sv
`timescale 1ns/100ps
module rx_desc_ring_bench;
  localparam int CEIL = 64;
  localparam int ND = 8;
  localparam logic [15:0] EMPTY = 16'h8000, WRAP = 16'h2000, LAST = 16'h0800;
  localparam logic [15:0] LERR = 16'h0020, TRUNC = 16'h0001;
  // {len[48:33], shift[32], max_buf[31:16], limit[15:0]}
  localparam logic [48:0] VEC [8] = '{
    {16'd10, 1'b0, 16'h0030, 16'd1000},
    {16'd44, 1'b0, 16'h0030, 16'd1000},
    {16'd45, 1'b0, 16'h0030, 16'd1000},
    {16'd30, 1'b1, 16'h0010, 16'd1000},
    {16'd40, 1'b0, 16'h0010, 16'd20},
    {16'd70, 1'b0, 16'h0030, 16'd1000},
    {16'd13, 1'b1, 16'h001F, 16'd1000},
    {16'd0,  1'b0, 16'h0030, 16'd1000}
  };

  logic clk = 0, rst_n = 0, enable = 0, arm_req = 0, shift_en = 0;
  logic [31:0] ring_base = 0;
  logic [15:0] max_buf = 16'h30, len_limit = 16'd1000;
  logic hdr_valid = 0, in_valid = 0;
  logic [15:0] hdr_len = 0;
  logic [31:0] hdr_crc = 0;
  logic [7:0] in_data = 0;
  logic hdr_ready, in_ready, mem_req, mem_we, rx_active, frame_evt, buf_evt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic mem_gnt = 1;
  logic stall = 0;
  logic [31:0] mem [256];
  int n_chk = 0, n_fail = 0, n_frm = 0, n_buf = 0, cyc = 0, nd = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_desc_ring #(.AW(32), .FRAME_CEIL(CEIL)) u_rx_desc_ring (
    .clk(clk), .rst_n(rst_n), .enable(enable), .arm_req(arm_req), .shift_en(shift_en),
    .ring_base(ring_base), .max_buf(max_buf), .len_limit(len_limit),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_len(hdr_len), .hdr_crc(hdr_crc),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .rx_active(rx_active), .frame_evt(frame_evt), .buf_evt(buf_evt));

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk)
    if (mem_req && mem_gnt && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];

  always @(negedge clk) begin
    cyc++;
    mem_gnt = stall ? (cyc % 3 != 0) : 1'b1;
    if (frame_evt) n_frm++;
    if (buf_evt) n_buf++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int f, int k);
    return 8'(f * 17 + k * 3 + 1);
  endfunction

  function automatic logic [7:0] rd_byte(int a);
    logic [31:0] w;
    w = mem[(a >> 2) & 255];
    return w[8*(a%4) +: 8];
  endfunction

  function automatic logic [7:0] exp_byte(int f, int k, int total, bit pad, logic [31:0] crc);
    if (pad && k < 2) return 8'h00;
    if (k >= total - 4) return crc[8*(3-(k-(total-4))) +: 8];
    return pat(f, k - (pad ? 2 : 0));
  endfunction

  task automatic arm_desc(int d);
    mem[2*d] = {EMPTY | ((d == ND-1) ? WRAP : 16'h0), 16'h0};
    mem[2*d+1] = 32'h100 + d * 64;
    for (int j = 0; j < 16; j++) mem[64 + d*16 + j] = 32'hA5A5A5A5;
  endtask

  task automatic wait_idle();
    @(negedge clk); #1;
    while (!hdr_ready) begin @(negedge clk); #1; end
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(int f, int len, logic [31:0] crc);
    @(negedge clk);
    hdr_valid = 1; hdr_len = 16'(len); hdr_crc = crc; #1;
    while (!hdr_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    hdr_valid = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1; in_data = pat(f, k); #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
    end
    in_valid = 0;
    wait_idle();
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm_req = 1;
    @(negedge clk); arm_req = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_vec(int f, int len, bit sh, int mbs_raw, int lim, string tag);
    int raw, total, mbs, rem, k, used, chunk, d0, f0, b0;
    bit tr, le, fin;
    logic [15:0] fl;
    logic [7:0] got, expv;
    logic [31:0] crc;
    crc = 32'h1234_5678 ^ (f * 32'h1111_1111);
    @(negedge clk);
    shift_en = sh; max_buf = 16'(mbs_raw); len_limit = 16'(lim);
    f0 = n_frm; b0 = n_buf; d0 = nd;
    send_frame(f, len, crc);
    raw = len + 4 + (sh ? 2 : 0);
    tr = raw > CEIL;
    total = tr ? CEIL : raw;
    le = tr || total > lim;
    mbs = mbs_raw & 32'h3FF0;
    rem = total; k = 0; used = 0;
    while (rem > 0) begin
      chunk = (rem < mbs) ? rem : mbs;
      fin = (chunk == rem);
      fl = ((nd == ND-1) ? WRAP : 16'h0) |
           (fin ? (LAST | (le ? LERR : 16'h0) | (tr ? TRUNC : 16'h0)) : 16'h0);
      chk($sformatf("%s R5 R7 desc word (frame %0d desc %0d)", tag, f, nd), mem[2*nd], {fl, 16'(chunk)});
      got = 0; expv = 0;
      for (int j = 0; j < chunk; j++) begin
        if (got == expv && rd_byte(32'h100 + nd*64 + j) !== exp_byte(f, k + j, total, sh, crc)) begin
          got = rd_byte(32'h100 + nd*64 + j);
          expv = exp_byte(f, k + j, total, sh, crc);
        end
      end
      chk($sformatf("%s R2 buffer bytes (frame %0d desc %0d)", tag, f, nd), {24'h0, got}, {24'h0, expv});
      rem -= chunk; k += chunk; used++;
      nd = (nd + 1) % ND;
    end
    chk($sformatf("R7 frame events (frame %0d)", f), n_frm - f0, 1);
    chk($sformatf("R7 buffer events (frame %0d)", f), n_buf - b0, used - 1);
    chk($sformatf("R11 active after frame %0d", f), {31'h0, rx_active}, 1);
    for (int u = 0; u < used; u++) arm_desc((d0 + u) % ND);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA5A5A5A5;
    for (int d = 0; d < ND; d++) arm_desc(d);
    repeat (3) @(negedge clk);
    chk("reset rx_active", {31'h0, rx_active}, 0);
    chk("reset events", {30'h0, frame_evt, buf_evt}, 0);
    chk("reset mem_req", {31'h0, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("reset hdr_ready", {31'h0, hdr_ready}, 1);

    // R12: arm ignored while disabled
    pulse_arm();
    chk("R12 arm while disabled", {31'h0, rx_active}, 0);

    // R1: frame dropped while inactive
    enable = 1;
    repeat (2) @(negedge clk);
    send_frame(99, 6, 32'hDEADBEEF);
    chk("R1 dropped frame desc untouched", mem[0], {EMPTY, 16'h0});
    chk("R1 dropped frame buffer untouched", mem[64], 32'hA5A5A5A5);
    chk("R1 dropped frame events", n_frm + n_buf, 0);

    // R12: arm while enabled
    pulse_arm();
    chk("R12 arm while enabled", {31'h0, rx_active}, 1);

    for (int i = 0; i < 8; i++) begin
      string tag;
      case (i)
        0: tag = "R2 single";
        1: tag = "R5 exact fill";
        2: tag = "R6 straddle";
        3: tag = "R10 pad";
        4: tag = "R4 limit";
        5: tag = "R3 ceiling";
        6: tag = "R5 mask R10";
        default: tag = "R2 empty payload R9 wrap";
      endcase
      stall = (i >= 4);
      run_vec(i, int'(VEC[i][48:33]), VEC[i][32], int'(VEC[i][31:16]), int'(VEC[i][15:0]), tag);
    end
    chk("R9 pointer wrapped", nd, 7);

    // R8: abandon on a full descriptor
    begin
      int a, b, f0, b0;
      logic [31:0] saved;
      logic [7:0] got, expv;
      a = nd; b = (nd + 1) % ND;
      mem[2*b] = mem[2*b] & ~{EMPTY, 16'h0};
      saved = mem[2*b];
      stall = 0;
      @(negedge clk);
      shift_en = 0; max_buf = 16'h10; len_limit = 16'd1000;
      f0 = n_frm; b0 = n_buf;
      send_frame(20, 40, 32'hCAFEF00D);
      chk("R8 first desc written", mem[2*a], {((a == ND-1) ? WRAP : 16'h0), 16'd16});
      got = 0; expv = 0;
      for (int j = 0; j < 16; j++)
        if (got == expv && rd_byte(32'h100 + a*64 + j) !== pat(20, j)) begin
          got = rd_byte(32'h100 + a*64 + j); expv = pat(20, j);
        end
      chk("R8 first buffer bytes", {24'h0, got}, {24'h0, expv});
      chk("R8 full desc untouched", mem[2*b], saved);
      chk("R8 no frame event", n_frm - f0, 0);
      chk("R8 one buffer event", n_buf - b0, 1);
      chk("R8 active cleared", {31'h0, rx_active}, 0);
      f0 = n_frm; b0 = n_buf;
      send_frame(21, 5, 32'h0BADF00D);
      chk("R1 drop after abandon desc", mem[2*b], saved);
      chk("R1 drop after abandon events", (n_frm - f0) + (n_buf - b0), 0);
      arm_desc(a); arm_desc(b);
      pulse_arm();
      chk("R12 re-arm after abandon", {31'h0, rx_active}, 1);
      nd = b;
      run_vec(22, 8, 1'b0, 16'h30, 1000, "R8 resume");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    done = 1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule